// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block keeps the configuration of a small set of hardware debug triggers and presents it through a single-cycle register port. A select register picks one trigger. Two data registers then reach that trigger. The control register splits a written word into per-trigger fields: compare kind, action, chaining, match mode, four privilege enables and the fetch/load/store enables. On a read it packs those fields back into a word, together with a fixed type code and a read-only mask-limit field. The auxiliary register is a plain full-width word for each trigger. The address comparators and the halt or exception actions sit outside this block.

Alongside the registers, the block drives three summary enables. They tell the instruction-fetch, load and store paths whether any armed trigger watches them. A small state machine rebuilds these enables after every accepted control write. It has two states. `SCAN_IDLE` holds the published enables. The transition *start* (a control write with an in-range select) clears the enables and enters `SCAN_RUN`. `SCAN_RUN` visits one trigger per cycle and ORs its enables into an accumulator, skipping triggers whose action is "none". The transition *finish* (the last trigger has been visited) publishes the accumulator and returns to `SCAN_IDLE`. The transition *restart* (another start while in `SCAN_RUN`) begins the scan again from trigger 0. Each start also raises a one-cycle request to flush the address-translation cache.

Top module: `trig_bank`

## Requirements
- R1: After reset the select register reads 0. Each trigger's control register reads only the type code 2 in bits XLEN-1..XLEN-4, and each auxiliary register reads 0. All three check enables and the flush request are 0.
- R2: A write to the select register (address 0x7A0) stores the full XLEN-bit value unchanged, and a read returns it.
- R3: Control register (address 0x7A1) layout, read and write. Writable fields: bit 19 compare kind, bits 15..12 action, bit 11 chain, bits 10..7 match mode, bits 6..3 privilege enables, bit 2 execute, bit 1 store, bit 0 load. On a read, bits XLEN-1..XLEN-4 give the type code 2 and bits XLEN-5..XLEN-10 give a mask-limit field of 0. All other bits read 0.
- R4: The auxiliary register (address 0x7A2) stores a full XLEN-bit word for each trigger, reached through the select value.
- R5: When the select value is not less than NUM_TRIG, a write to the control or auxiliary register changes no trigger. It raises no flush request and leaves the check enables unchanged.
- R6: When the select value is not less than NUM_TRIG, a read of the control or auxiliary register returns 0.
- R7: A read of any address other than 0x7A0..0x7A2 returns 0. A write to such an address has no effect.
- R8: An accepted control write raises the flush request for exactly the one cycle after the write edge. Auxiliary writes do not raise it.
- R9: From the write edge of an accepted control write until the scan finishes, all three check enables are 0.
- R10: NUM_TRIG cycles after the write edge, each enable holds the OR of its bit over the triggers whose action field is not 0 ("none"). The fetch enable uses bit 2, the load enable bit 0 and the store enable bit 1.
- R11: An accepted control write during a scan restarts the scan. The enables stay 0 for NUM_TRIG cycles after the newer write, then reflect all triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe for the register port |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for csr_addr |
| fetch_chk_en | output | 1 | Some armed trigger watches instruction fetch |
| load_chk_en | output | 1 | Some armed trigger watches loads |
| store_chk_en | output | 1 | Some armed trigger watches stores |
| xlat_flush | output | 1 | One-cycle translation-cache flush request |

## Verification
The unpacking is tested three ways. All-ones control words show that only the listed fields stick and that the type code cannot be overwritten. Random words check the remaining field boundaries. Armed-versus-disarmed pairs show that a trigger with action 0 adds nothing to the enables, even when its execute/load/store bits are set. Select values equal to NUM_TRIG and all ones tell the in-range test apart from a truncated index compare. Back-to-back control writes show a restart of the scan, as opposed to a scan that runs to completion on stale data.

// File: rtl/trig_pkg.sv
package trig_pkg;

    // Low part of the control word that carries writable fields
    localparam int CTL_LO_W   = 20;
    localparam int POS_KIND   = 19;
    localparam int POS_ACT    = 12;
    localparam int POS_CHAIN  = 11;
    localparam int POS_MATCH  = 7;
    localparam int POS_PRIV   = 3;
    localparam int POS_EXEC   = 2;
    localparam int POS_STORE  = 1;
    localparam int POS_LOAD   = 0;

    localparam logic [3:0] TRIG_TYPE_CODE = 4'd2;
    localparam logic [5:0] MASK_LIMIT     = 6'd0;
    localparam logic [3:0] ACT_NONE       = 4'd0;

    typedef struct packed {
        logic       cmp_kind;
        logic [3:0] action;
        logic       chain_nxt;
        logic [3:0] match_mode;
        logic [3:0] priv_en;   // m, h, s, u from high to low
        logic       en_fetch;
        logic       en_store;
        logic       en_load;
    } trig_ctl_t;

    typedef enum logic {
        SCAN_IDLE,
        SCAN_RUN
    } scan_state_e;

    function automatic trig_ctl_t unpack_ctl(input logic [CTL_LO_W-1:0] w);
        trig_ctl_t c;
        c.cmp_kind   = w[POS_KIND];
        c.action     = w[POS_ACT +: 4];
        c.chain_nxt  = w[POS_CHAIN];
        c.match_mode = w[POS_MATCH +: 4];
        c.priv_en    = w[POS_PRIV +: 4];
        c.en_fetch   = w[POS_EXEC];
        c.en_store   = w[POS_STORE];
        c.en_load    = w[POS_LOAD];
        return c;
    endfunction

    function automatic logic [CTL_LO_W-1:0] pack_ctl(input trig_ctl_t c);
        logic [CTL_LO_W-1:0] w;
        w = '0;
        w[POS_KIND]       = c.cmp_kind;
        w[POS_ACT +: 4]   = c.action;
        w[POS_CHAIN]      = c.chain_nxt;
        w[POS_MATCH +: 4] = c.match_mode;
        w[POS_PRIV +: 4]  = c.priv_en;
        w[POS_EXEC]       = c.en_fetch;
        w[POS_STORE]      = c.en_store;
        w[POS_LOAD]       = c.en_load;
        return w;
    endfunction

endpackage

// File: rtl/trig_csr_decode.sv
module trig_csr_decode #(
    parameter int          XLEN     = 64,
    parameter int          NUM_TRIG = 4,
    parameter logic [11:0] ADDR_SEL = 12'h7A0,
    parameter logic [11:0] ADDR_CTL = 12'h7A1,
    parameter logic [11:0] ADDR_AUX = 12'h7A2,
    localparam int         IDX_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic             csr_we,
    input  logic [11:0]      csr_addr,
    input  logic [XLEN-1:0]  sel_q,
    output logic             hit_sel,
    output logic             hit_ctl,
    output logic             hit_aux,
    output logic             in_range,
    output logic [IDX_W-1:0] idx,
    output logic             sel_we,
    output logic             ctl_we,
    output logic             aux_we
);

    always_comb begin
        hit_sel  = (csr_addr == ADDR_SEL);
        hit_ctl  = (csr_addr == ADDR_CTL);
        hit_aux  = (csr_addr == ADDR_AUX);
        in_range = (sel_q < XLEN'(NUM_TRIG));
        idx      = sel_q[IDX_W-1:0];
        sel_we   = csr_we && hit_sel;
        ctl_we   = csr_we && hit_ctl && in_range;
        aux_we   = csr_we && hit_aux && in_range;
    end

endmodule

// File: rtl/trig_slot.sv
module trig_slot
    import trig_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic            aux_we,
    input  logic [XLEN-1:0] wdata,
    output trig_ctl_t       ctl_q,
    output logic [XLEN-1:0] aux_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.action <= ACT_NONE;
            aux_q        <= '0;
        end else begin
            if (ctl_we) ctl_q <= unpack_ctl(wdata[CTL_LO_W-1:0]);
            if (aux_we) aux_q <= wdata;
        end
    end

endmodule

// File: rtl/trig_scan_fsm.sv
module trig_scan_fsm
    import trig_pkg::*;
#(
    parameter int  NUM_TRIG = 4,
    localparam int IDX_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  trig_ctl_t [NUM_TRIG-1:0] ctl_vec,
    output logic                     fetch_en,
    output logic                     load_en,
    output logic                     store_en,
    output logic                     flush_pulse
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_TRIG - 1);

    scan_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [2:0]       acc_q;
    logic [2:0]       en_q;
    logic [2:0]       contrib;
    trig_ctl_t        cur;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SCAN_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_IDLE: if (start) state_d = SCAN_RUN;
            SCAN_RUN: begin
                if (start)             state_d = SCAN_RUN;   // restart
                else if (idx_q == LAST) state_d = SCAN_IDLE; // finish
            end
        endcase
    end

    // contribution of the trigger under the scan pointer: {fetch, load, store}
    always_comb begin
        cur     = ctl_vec[idx_q];
        contrib = (cur.action != ACT_NONE) ? {cur.en_fetch, cur.en_load, cur.en_store} : 3'b000;
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q       <= '0;
            acc_q       <= '0;
            en_q        <= '0;
            flush_pulse <= 1'b0;
        end else begin
            flush_pulse <= start;
            if (start) begin
                idx_q <= '0;
                acc_q <= '0;
                en_q  <= '0;
            end else if (state_q == SCAN_RUN) begin
                acc_q <= acc_q | contrib;
                idx_q <= idx_q + 1'b1;
                if (idx_q == LAST) en_q <= acc_q | contrib;
            end
        end
    end

    assign fetch_en = en_q[2];
    assign load_en  = en_q[1];
    assign store_en = en_q[0];

endmodule

// File: rtl/trig_bank.sv
module trig_bank
    import trig_pkg::*;
#(
    parameter int          XLEN     = 64,
    parameter int          NUM_TRIG = 4,
    parameter logic [11:0] ADDR_SEL = 12'h7A0,
    parameter logic [11:0] ADDR_CTL = 12'h7A1,
    parameter logic [11:0] ADDR_AUX = 12'h7A2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            fetch_chk_en,
    output logic            load_chk_en,
    output logic            store_chk_en,
    output logic            xlat_flush
);

    localparam int IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

    logic [XLEN-1:0]                sel_q;
    logic                           hit_sel, hit_ctl, hit_aux, in_range;
    logic [IDX_W-1:0]               idx;
    logic                           sel_we, ctl_we, aux_we;
    trig_ctl_t [NUM_TRIG-1:0]       ctl_vec;
    logic [NUM_TRIG-1:0][XLEN-1:0]  aux_vec;
    logic [XLEN-1:0]                ctl_word;

    trig_csr_decode #(
        .XLEN(XLEN), .NUM_TRIG(NUM_TRIG),
        .ADDR_SEL(ADDR_SEL), .ADDR_CTL(ADDR_CTL), .ADDR_AUX(ADDR_AUX)
    ) u_dec (
        .csr_we(csr_we), .csr_addr(csr_addr), .sel_q(sel_q),
        .hit_sel(hit_sel), .hit_ctl(hit_ctl), .hit_aux(hit_aux),
        .in_range(in_range), .idx(idx),
        .sel_we(sel_we), .ctl_we(ctl_we), .aux_we(aux_we)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_we) sel_q <= csr_wdata;
    end

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
        trig_slot #(.XLEN(XLEN)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .ctl_we(ctl_we && (idx == IDX_W'(g))),
            .aux_we(aux_we && (idx == IDX_W'(g))),
            .wdata(csr_wdata),
            .ctl_q(ctl_vec[g]),
            .aux_q(aux_vec[g])
        );
    end

    trig_scan_fsm #(.NUM_TRIG(NUM_TRIG)) u_scan (
        .clk(clk), .rst_n(rst_n),
        .start(ctl_we),
        .ctl_vec(ctl_vec),
        .fetch_en(fetch_chk_en),
        .load_en(load_chk_en),
        .store_en(store_chk_en),
        .flush_pulse(xlat_flush)
    );

    always_comb begin
        ctl_word                  = '0;
        ctl_word[XLEN-1 -: 4]     = TRIG_TYPE_CODE;
        ctl_word[XLEN-5 -: 6]     = MASK_LIMIT;
        ctl_word[CTL_LO_W-1:0]    = pack_ctl(ctl_vec[idx]);
    end

    always_comb begin
        csr_rdata = '0;
        if (hit_sel)                  csr_rdata = sel_q;
        else if (hit_ctl && in_range) csr_rdata = ctl_word;
        else if (hit_aux && in_range) csr_rdata = aux_vec[idx];
    end

endmodule

// File: rtl/trig_bank_chk.sv
module trig_bank_chk #(
    parameter int          XLEN     = 64,
    parameter int          NUM_TRIG = 4,
    parameter logic [11:0] ADDR_SEL = 12'h7A0,
    parameter logic [11:0] ADDR_CTL = 12'h7A1,
    parameter logic [11:0] ADDR_AUX = 12'h7A2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            csr_we,
    input logic [11:0]     csr_addr,
    input logic [XLEN-1:0] csr_rdata,
    input logic [XLEN-1:0] sel_q,
    input logic            fetch_chk_en,
    input logic            load_chk_en,
    input logic            store_chk_en,
    input logic            xlat_flush
);

    logic sel_ok, ctl_acc, known_addr;
    assign sel_ok     = (sel_q < XLEN'(NUM_TRIG));
    assign ctl_acc    = csr_we && (csr_addr == ADDR_CTL) && sel_ok;
    assign known_addr = (csr_addr == ADDR_SEL) || (csr_addr == ADDR_CTL) || (csr_addr == ADDR_AUX);

    AST_TYPE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADDR_CTL && sel_ok) |-> csr_rdata[XLEN-1 -: 4] == 4'd2); // R3
    AST_OOR_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && (csr_addr == ADDR_CTL) && !sel_ok) |=> !xlat_flush); // R5
    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((csr_addr == ADDR_CTL || csr_addr == ADDR_AUX) && !sel_ok) |-> csr_rdata == '0); // R6
    AST_UNKNOWN_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !known_addr |-> csr_rdata == '0); // R7
    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_acc |=> xlat_flush); // R8
    AST_FLUSH_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_acc |=> !xlat_flush); // R8
    AST_EN_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_acc |=> !(fetch_chk_en || load_chk_en || store_chk_en)); // R9

endmodule

bind trig_bank trig_bank_chk #(
    .XLEN(XLEN), .NUM_TRIG(NUM_TRIG),
    .ADDR_SEL(ADDR_SEL), .ADDR_CTL(ADDR_CTL), .ADDR_AUX(ADDR_AUX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_rdata(csr_rdata), .sel_q(sel_q),
    .fetch_chk_en(fetch_chk_en), .load_chk_en(load_chk_en),
    .store_chk_en(store_chk_en), .xlat_flush(xlat_flush)
);

// File: tb/trig_bank_tb.sv
`timescale 1ns/1ps
module trig_bank_tb_top;

    localparam int          XLEN   = 64;
    localparam int          NTRIG  = 4;
    localparam logic [11:0] A_SEL  = 12'h7A0;
    localparam logic [11:0] A_CTL  = 12'h7A1;
    localparam logic [11:0] A_AUX  = 12'h7A2;
    localparam logic [XLEN-1:0] WMASK    = XLEN'(32'h0008_FFFF);
    localparam logic [XLEN-1:0] TYPE_TOP = XLEN'(2) << (XLEN - 4);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            csr_we;
    logic [11:0]     csr_addr;
    logic [XLEN-1:0] csr_wdata;
    logic [XLEN-1:0] csr_rdata;
    logic            fetch_chk_en, load_chk_en, store_chk_en, xlat_flush;

    always #4 clk = ~clk;   // 125 MHz

    trig_bank #(.XLEN(XLEN), .NUM_TRIG(NTRIG)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .fetch_chk_en(fetch_chk_en), .load_chk_en(load_chk_en),
        .store_chk_en(store_chk_en), .xlat_flush(xlat_flush)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model
    logic [XLEN-1:0] sel_m;
    logic [XLEN-1:0] ctl_m [NTRIG];
    logic [XLEN-1:0] aux_m [NTRIG];
    logic [2:0]      en_m;

    function automatic bit sel_in(input logic [XLEN-1:0] s);
        return s < XLEN'(NTRIG);
    endfunction

    function automatic logic [XLEN-1:0] exp_read(input logic [11:0] a);
        if (a == A_SEL) return sel_m;
        if (a == A_CTL) return sel_in(sel_m) ? (TYPE_TOP | ctl_m[sel_m[1:0]]) : '0;
        if (a == A_AUX) return sel_in(sel_m) ? aux_m[sel_m[1:0]] : '0;
        return '0;
    endfunction

    // {fetch, load, store}
    function automatic logic [2:0] exp_en();
        logic [2:0] e = 3'b000;
        for (int t = 0; t < NTRIG; t++)
            if (ctl_m[t][15:12] != 4'd0)
                e |= {ctl_m[t][2], ctl_m[t][0], ctl_m[t][1]};
        return e;
    endfunction

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] en_now();
        return {fetch_chk_en, load_chk_en, store_chk_en};
    endfunction

    // starts and ends at a falling edge
    task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
        if (a == A_SEL) sel_m = d;
        else if (a == A_CTL && sel_in(sel_m)) ctl_m[sel_m[1:0]] = d & WMASK;
        else if (a == A_AUX && sel_in(sel_m)) aux_m[sel_m[1:0]] = d;
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input string req);
        csr_addr = a; csr_we = 1'b0;
        #1;
        chk(req, csr_rdata, exp_read(a));
        @(negedge clk);
    endtask

    task automatic ctl_wr_chk(input logic [XLEN-1:0] d);
        bit ok = sel_in(sel_m);
        wr(A_CTL, d);
        if (ok) begin
            chk("R8 flush after control write", XLEN'(xlat_flush), 1);
            chk("R9 enables cleared", XLEN'(en_now()), 0);
            for (int k = 1; k < NTRIG; k++) begin
                @(negedge clk);
                chk("R9 enables held clear during scan", XLEN'(en_now()), 0);
                chk("R8 flush single cycle", XLEN'(xlat_flush), 0);
            end
            @(negedge clk);
            en_m = exp_en();
            chk("R10 enables after scan", XLEN'(en_now()), XLEN'(en_m));
        end else begin
            chk("R5 no flush out of range", XLEN'(xlat_flush), 0);
            chk("R5 enables unchanged", XLEN'(en_now()), XLEN'(en_m));
        end
    endtask

    task automatic read_all(input string req);
        logic [XLEN-1:0] keep = sel_m;
        for (int t = 0; t < NTRIG; t++) begin
            wr(A_SEL, XLEN'(t));
            rd_chk(A_CTL, req);
            rd_chk(A_AUX, req);
        end
        wr(A_SEL, keep);
    endtask

    function automatic logic [11:0] odd_addr();
        logic [11:0] a = 12'($urandom);
        if (a >= A_SEL && a <= A_AUX) a = a + 12'd8;
        return a;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
        sel_m = '0; en_m = '0;
        for (int t = 0; t < NTRIG; t++) begin ctl_m[t] = '0; aux_m[t] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 flush at reset", XLEN'(xlat_flush), 0);
        chk("R1 enables at reset", XLEN'(en_now()), 0);
        rd_chk(A_SEL, "R1 select at reset");
        read_all("R1 trigger regs at reset");

        // R2 select keeps any value
        wr(A_SEL, 64'hDEAD_BEEF_0123_4567);
        rd_chk(A_SEL, "R2 select readback");

        // R3 layout, R10 aggregation
        wr(A_SEL, 1);
        ctl_wr_chk('1);
        rd_chk(A_CTL, "R3 all-ones control readback");
        ctl_wr_chk(64'h0000_0000_0000_0007);   // disarmed, enables set
        rd_chk(A_CTL, "R3 control fields");
        wr(A_SEL, 2);
        ctl_wr_chk(64'h0000_0000_0000_3001);   // armed, load only
        wr(A_SEL, 3);
        ctl_wr_chk(64'h0000_0000_0000_1004);   // armed, fetch only
        wr(A_SEL, 0);
        ctl_wr_chk(64'h0000_0000_0000_F002);   // armed, store only

        // R4 aux storage
        for (int t = 0; t < NTRIG; t++) begin
            wr(A_SEL, XLEN'(t));
            wr(A_AUX, {$urandom, $urandom});
            chk("R8 no flush on aux write", XLEN'(xlat_flush), 0);
        end
        read_all("R4 aux per trigger");

        // R5 / R6 out-of-range select
        wr(A_SEL, XLEN'(NTRIG));
        rd_chk(A_CTL, "R6 control read out of range");
        rd_chk(A_AUX, "R6 aux read out of range");
        ctl_wr_chk('1);
        wr(A_AUX, '1);
        wr(A_SEL, '1);
        rd_chk(A_CTL, "R6 control read select all ones");
        ctl_wr_chk(64'h0000_0000_0000_1007);
        read_all("R5 triggers untouched");

        // R7 unsupported addresses
        for (int k = 0; k < 6; k++) begin
            logic [11:0] a = odd_addr();
            rd_chk(a, "R7 unsupported read");
            wr(a, {$urandom, $urandom});
            chk("R7 no flush on unsupported write", XLEN'(xlat_flush), 0);
            chk("R7 enables unchanged", XLEN'(en_now()), XLEN'(en_m));
        end
        read_all("R7 state after unsupported writes");

        // R11 restart during scan
        wr(A_SEL, 1);
        wr(A_CTL, 64'h0000_0000_0000_0000);
        chk("R11 first write clears", XLEN'(en_now()), 0);
        @(negedge clk);
        wr(A_SEL, 2);
        ctl_wr_chk(64'h0000_0000_0000_2006);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom_range(0, 6));
            case (op)
                0: wr(A_SEL, ($urandom_range(0, 9) == 0) ? {$urandom, $urandom} : XLEN'($urandom_range(0, NTRIG)));
                1, 2: ctl_wr_chk({$urandom, $urandom});
                3: wr(A_AUX, {$urandom, $urandom});
                4: rd_chk(A_CTL, "R3 random control read");
                5: rd_chk(A_AUX, "R4 random aux read");
                default: rd_chk(odd_addr(), "R7 random unsupported read");
            endcase
        end
        read_all("R10 final state");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule